// File: doc/BRIEF.md
# Boot Remap and Address Decoder

This block sits on the processor bus and sorts each access into one destination: boot memory, internal SRAM, internal peripherals or one of the external chip-select banks. The lowest megabyte of the address space holds the exception vectors. After reset this low window reaches the boot device on chip-select 0. Software moves the window to internal SRAM by setting a sticky remap bit. Only a reset clears that bit.

Before remap, only chip-select 0 can be reached in the external space. An access to an external address that no enabled bank claims raises abort. Accesses to internal memory or to the peripheral area never abort. A control bit picks the external bank layout: eight 1 MB banks or four 16 MB banks. The boot-mode pin is captured once after reset and reported as the width of the boot device.

Every decode result appears on registered outputs one clock after the access strobe. The decode uses the map that is in force before any control write made in the same cycle.

Top module: `boot_remap_decode`

## Requirements
- R1: While reset is asserted, and directly after it, `remapped_o` is 0 and every select, chip-select and abort output is 0.
- R2: Before remap, an access to 0x0000_0000–0x000F_FFFF drives `sel_boot_o` and `cs_o[0]` high one cycle after the strobe.
- R3: A control write with `cfg_wdata_i[0]`=1 sets remap from the next cycle on. After that, the low window drives `sel_sram_o` instead. An access made in the cycle of the write still uses the old map.
- R4: Writing `cfg_wdata_i[0]`=0 never clears remap. Only reset clears it.
- R5: Before remap, an external address inside bank 1 to 7 gives abort and no chip-select.
- R6: An external address inside an enabled bank raises exactly the one bit of `cs_o` for that bank.
- R7: An address in 0x0040_0000–0xFFBF_FFFF that no enabled bank claims gives `abort_o`=1 and no select.
- R8: Addresses from 0xFFC0_0000 up drive `sel_periph_o`. Addresses 0x0030_0000–0x003F_FFFF drive `sel_sram_o`. The internal gap 0x0010_0000–0x002F_FFFF selects nothing. None of these ever aborts.
- R9: `boot_narrow_o` takes `boot_sel_i` at the first clock edge after reset release and ignores the pin afterwards. A value of 1 means an 8-bit boot device and 0 means a 16-bit boot device.
- R10: Control bit `cfg_wdata_i[1]` holds the layout and is rewritten on every control write. With the bit at 0, bank i covers 0x0040_0000 + i·1 MB for i = 0..7. With the bit at 1, bank i covers 0x0100_0000 + i·16 MB for i = 0..3.
- R11: A cycle without a strobe leaves every select, chip-select and abort output at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access strobe |
| bus_addr_i | input | 32 | Access address |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 2 | Control write data: bit 0 remap, bit 1 wide banks |
| boot_sel_i | input | 1 | Boot-mode pin: 1 = 8-bit and 0 = 16-bit boot device |
| sel_boot_o | output | 1 | Boot memory selected |
| sel_sram_o | output | 1 | Internal SRAM selected |
| sel_periph_o | output | 1 | Internal peripheral selected |
| cs_o | output | 8 | External chip-selects, one-hot |
| abort_o | output | 1 | Undefined external address |
| remapped_o | output | 1 | Remap state |
| boot_narrow_o | output | 1 | Latched boot width, 1 = 8-bit |

## Verification
The assertions assume that each strobe carries a stable, fully defined address in its cycle. They also assume that reset lasts at least one clock edge, so the pin-capture edge comes after a clean reset. The bench drives every input on the falling edge and holds it for a whole cycle. It releases reset between edges with the boot pin already set, and it toggles the pin only after the capture edge.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

    localparam int ADDR_W  = 32;
    localparam int NUM_CS  = 8;
    localparam int CTRL_W  = 2;
    localparam int REMAP_BIT = 0;
    localparam int WIDE_BIT  = 1;

    localparam logic [31:0] LOW_TOP     = 32'h0010_0000;
    localparam logic [31:0] SRAM_LO     = 32'h0030_0000;
    localparam logic [31:0] EXT_LO      = 32'h0040_0000;
    localparam logic [31:0] EXT_HI      = 32'hFFC0_0000;
    localparam logic [31:0] SMALL_BASE  = 32'h0040_0000;
    localparam logic [31:0] SMALL_SIZE  = 32'h0010_0000;
    localparam logic [31:0] LARGE_BASE  = 32'h0100_0000;
    localparam logic [31:0] LARGE_SIZE  = 32'h0100_0000;

    typedef struct packed {
        logic low;
        logic sram;
        logic periph;
        logic ext;
    } region_t;

    typedef struct packed {
        logic              remap;
        logic              wide;
        logic              armed;
        logic              narrow;
        logic              sel_boot;
        logic              sel_sram;
        logic              sel_periph;
        logic              abort;
        logic [NUM_CS-1:0] cs;
    } dec_state_t;

endpackage

// File: rtl/brd_region_decode.sv
module brd_region_decode
    import boot_map_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    output region_t       region_o
);
    always_comb begin
        region_o.low    = (addr_i < AW'(LOW_TOP));
        region_o.sram   = (addr_i >= AW'(SRAM_LO)) && (addr_i < AW'(EXT_LO));
        region_o.ext    = (addr_i >= AW'(EXT_LO)) && (addr_i < AW'(EXT_HI));
        region_o.periph = (addr_i >= AW'(EXT_HI));
    end
endmodule

// File: rtl/brd_bank_decode.sv
module brd_bank_decode
    import boot_map_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int BANKS = NUM_CS
) (
    input  logic [AW-1:0]    addr_i,
    input  logic             wide_i,
    output logic [BANKS-1:0] hit_o
);
    localparam int WIDE_BANKS = BANKS / 2;

    logic [BANKS-1:0] small_hit;
    logic [BANKS-1:0] large_hit;

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        localparam logic [AW-1:0] S_LO = AW'(SMALL_BASE + i * SMALL_SIZE);
        localparam logic [AW-1:0] S_HI = AW'(SMALL_BASE + (i + 1) * SMALL_SIZE);
        assign small_hit[i] = (addr_i >= S_LO) && (addr_i < S_HI);
        if (i < WIDE_BANKS) begin : g_large
            localparam logic [AW-1:0] L_LO = AW'(LARGE_BASE + i * LARGE_SIZE);
            localparam logic [AW-1:0] L_HI = AW'(LARGE_BASE + (i + 1) * LARGE_SIZE);
            assign large_hit[i] = (addr_i >= L_LO) && (addr_i < L_HI);
        end else begin : g_none
            assign large_hit[i] = 1'b0;
        end
    end

    assign hit_o = wide_i ? large_hit : small_hit;
endmodule

// File: rtl/boot_remap_decode.sv
module boot_remap_decode
    import boot_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              cfg_we_i,
    input  logic [CTRL_W-1:0] cfg_wdata_i,
    input  logic              boot_sel_i,
    output logic              sel_boot_o,
    output logic              sel_sram_o,
    output logic              sel_periph_o,
    output logic [NUM_CS-1:0] cs_o,
    output logic              abort_o,
    output logic              remapped_o,
    output logic              boot_narrow_o
);
    localparam logic [NUM_CS-1:0] CS0_ONLY = NUM_CS'(1);

    region_t           region;
    logic [NUM_CS-1:0] bank_hit;
    logic [NUM_CS-1:0] allowed;
    dec_state_t        st_d, st_q;

    brd_region_decode #(.AW(ADDR_W)) u_region (
        .addr_i   (bus_addr_i),
        .region_o (region)
    );

    brd_bank_decode #(.AW(ADDR_W), .BANKS(NUM_CS)) u_bank (
        .addr_i (bus_addr_i),
        .wide_i (st_q.wide),
        .hit_o  (bank_hit)
    );

    assign allowed = st_q.remap ? bank_hit : (bank_hit & CS0_ONLY);

    always_comb begin
        st_d            = st_q;
        st_d.sel_boot   = 1'b0;
        st_d.sel_sram   = 1'b0;
        st_d.sel_periph = 1'b0;
        st_d.abort      = 1'b0;
        st_d.cs         = '0;

        if (!st_q.armed) begin
            st_d.armed  = 1'b1;
            st_d.narrow = boot_sel_i;
        end

        if (bus_valid_i) begin
            if (region.low) begin
                if (st_q.remap) begin
                    st_d.sel_sram = 1'b1;
                end else begin
                    st_d.sel_boot = 1'b1;
                    st_d.cs       = CS0_ONLY;
                end
            end else if (region.sram) begin
                st_d.sel_sram = 1'b1;
            end else if (region.periph) begin
                st_d.sel_periph = 1'b1;
            end else if (region.ext) begin
                if (|allowed) begin
                    st_d.cs = allowed;
                end else begin
                    st_d.abort = 1'b1;
                end
            end
        end

        if (cfg_we_i) begin
            if (cfg_wdata_i[REMAP_BIT]) begin
                st_d.remap = 1'b1;
            end
            st_d.wide = cfg_wdata_i[WIDE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_boot_o    = st_q.sel_boot;
    assign sel_sram_o    = st_q.sel_sram;
    assign sel_periph_o  = st_q.sel_periph;
    assign cs_o          = st_q.cs;
    assign abort_o       = st_q.abort;
    assign remapped_o    = st_q.remap;
    assign boot_narrow_o = st_q.narrow;
endmodule

// File: rtl/brd_checker.sv
module brd_checker
    import boot_map_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              sel_boot_o,
    input logic              sel_sram_o,
    input logic              sel_periph_o,
    input logic [NUM_CS-1:0] cs_o,
    input logic              abort_o,
    input logic              remapped_o,
    input logic              boot_narrow_o
);
    localparam logic [NUM_CS-1:0] UPPER_CS = ~NUM_CS'(1);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o)); // R6

    AST_ABORT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (cs_o == '0) && !sel_boot_o && !sel_sram_o && !sel_periph_o); // R7

    AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        remapped_o |=> remapped_o); // R4

    AST_UPPER_CS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_o & UPPER_CS) != '0) |-> $past(remapped_o)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid_i |=> (cs_o == '0) && !abort_o && !sel_boot_o && !sel_sram_o && !sel_periph_o); // R11

    AST_PERIPH_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_addr_i >= ADDR_W'(EXT_HI)) |=> (sel_periph_o && !abort_o)); // R8

    AST_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> $stable(boot_narrow_o)); // R9

    AST_BOOT_PRE_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        sel_boot_o |-> cs_o[0] && !$past(remapped_o)); // R2
endmodule

bind boot_remap_decode brd_checker u_brd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid_i   (bus_valid_i),
    .bus_addr_i    (bus_addr_i),
    .sel_boot_o    (sel_boot_o),
    .sel_sram_o    (sel_sram_o),
    .sel_periph_o  (sel_periph_o),
    .cs_o          (cs_o),
    .abort_o       (abort_o),
    .remapped_o    (remapped_o),
    .boot_narrow_o (boot_narrow_o)
);

// File: tb/boot_remap_decode_test.sv
module boot_remap_decode_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid_i = 1'b0;
    logic [31:0] bus_addr_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_wdata_i = '0;
    logic        boot_sel_i = 1'b0;
    logic        sel_boot_o, sel_sram_o, sel_periph_o, abort_o, remapped_o, boot_narrow_o;
    logic [7:0]  cs_o;

    int applied = 0;
    int errors  = 0;

    logic m_remap = 1'b0;
    logic m_wide  = 1'b0;
    logic m_narrow = 1'b0;

    logic [13:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] adr_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    boot_remap_decode uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_valid_i   (bus_valid_i),
        .bus_addr_i    (bus_addr_i),
        .cfg_we_i      (cfg_we_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .boot_sel_i    (boot_sel_i),
        .sel_boot_o    (sel_boot_o),
        .sel_sram_o    (sel_sram_o),
        .sel_periph_o  (sel_periph_o),
        .cs_o          (cs_o),
        .abort_o       (abort_o),
        .remapped_o    (remapped_o),
        .boot_narrow_o (boot_narrow_o)
    );

    // Packing: {boot, sram, periph, abort, cs[7:0], remapped, narrow}
    function automatic logic [11:0] decode_model(input logic v, input logic [31:0] a,
                                                 input logic rm, input logic wd);
        logic       hit = 1'b0;
        int         idx = 0;
        logic [7:0] cs = '0;
        if (!v) return '0;
        if (a < 32'h0010_0000) begin
            if (rm) return {4'b0100, 8'h00};
            return {4'b1000, 8'h01};
        end
        if (a >= 32'h0030_0000 && a < 32'h0040_0000) return {4'b0100, 8'h00};
        if (a >= 32'hFFC0_0000) return {4'b0010, 8'h00};
        if (a < 32'h0040_0000) return '0;
        if (!wd && a < 32'h00C0_0000) begin
            hit = 1'b1;
            idx = int'((a - 32'h0040_0000) >> 20);
        end
        if (wd && a >= 32'h0100_0000 && a < 32'h0500_0000) begin
            hit = 1'b1;
            idx = int'((a - 32'h0100_0000) >> 24);
        end
        if (hit && (rm || idx == 0)) begin
            cs[idx] = 1'b1;
            return {4'b0000, cs};
        end
        return {4'b0001, 8'h00};
    endfunction

    task automatic drive(input logic v, input logic [31:0] a, input logic we,
                         input logic [1:0] wd, input string tag);
        logic [11:0] dec;
        @(negedge clk);
        bus_valid_i = v;
        bus_addr_i  = a;
        cfg_we_i    = we;
        cfg_wdata_i = wd;
        dec = decode_model(v, a, m_remap, m_wide);
        if (we) begin
            if (wd[0]) m_remap = 1'b1;
            m_wide = wd[1];
        end
        exp_q.push_back({dec, m_remap, m_narrow});
        tag_q.push_back(tag);
        adr_q.push_back(a);
    endtask

    task automatic access(input logic [31:0] a, input string tag);
        drive(1'b1, a, 1'b0, 2'b00, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 32'h0, 1'b0, 2'b00, tag);
    endtask

    task automatic direct_check(input logic [13:0] act, input logic [13:0] exp, input string tag);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            logic [13:0] exp, act;
            string       tag;
            logic [31:0] a;
            exp = exp_q.pop_front();
            tag = tag_q.pop_front();
            a   = adr_q.pop_front();
            act = {sel_boot_o, sel_sram_o, sel_periph_o, abort_o, cs_o, remapped_o, boot_narrow_o};
            applied++;
            if (act !== exp) begin
                errors++;
                $display("FAIL %s addr=%h act=%b exp=%b", tag, a, act, exp);
            end
        end
    end

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 1'b0;
        bus_valid_i = 1'b0;
        cfg_we_i = 1'b0;
        boot_sel_i = pin;
        #1;
        direct_check({sel_boot_o, sel_sram_o, sel_periph_o, abort_o, cs_o, remapped_o, 1'b0},
                     14'b0, "R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        m_remap = 1'b0;
        m_wide  = 1'b0;
        m_narrow = pin;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        do_reset(1'b1);
        idle("R1 after reset");
        access(32'h0000_0000, "R2 low window boot");
        access(32'h0000_001C, "R2 vector slot");
        idle("R11 idle");
        access(32'h0030_0010, "R8 sram direct");
        access(32'hFFC0_0000, "R8 periph low edge");
        access(32'hFFFF_FFFC, "R8 periph top");
        access(32'h0010_0000, "R8 internal gap");
        access(32'h002F_FFFC, "R8 gap top");
        boot_sel_i = 1'b0;
        access(32'h0040_0000, "R6 bank0 pre-remap");
        access(32'h0050_0000, "R5 bank1 blocked");
        access(32'h00B0_0000, "R5 bank7 blocked");
        access(32'h00C0_0000, "R7 miss small layout");
        access(32'h8000_0000, "R7 miss high");
        access(32'hFFBF_FFFC, "R7 miss external top");
        idle("R9 pin change ignored");
        drive(1'b0, 32'h0, 1'b1, 2'b10, "R10 wide write");
        access(32'h0100_0000, "R10 wide bank0");
        access(32'h0200_0000, "R5 wide bank1 blocked");
        access(32'h0050_0000, "R10 small address misses in wide");
        drive(1'b1, 32'h0000_0004, 1'b1, 2'b11, "R3 same-cycle old map");
        access(32'h0000_0004, "R3 low window now sram");
        access(32'h0200_0000, "R6 wide bank1");
        access(32'h04FF_FFFC, "R6 wide bank3 top");
        access(32'h0500_0000, "R7 wide miss");
        drive(1'b0, 32'h0, 1'b1, 2'b00, "R4 write zero keeps remap");
        access(32'h0050_0000, "R10 small bank1");
        access(32'h00B0_0000, "R6 small bank7");
        access(32'h0000_0000, "R4 still sram");
        access(32'h0020_0000, "R8 gap after remap");
        idle("R11 final idle");
        repeat (3) @(negedge clk);
        do_reset(1'b0);
        idle("R1 remap cleared");
        access(32'h0000_0000, "R4 reset restores boot");
        access(32'h0060_0000, "R5 blocked again");
        boot_sel_i = 1'b1;
        idle("R9 narrow stays 0");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule